// File: doc/BRIEF.md
# Incremental AES-128 Round-Key Generator

This block supplies the eleven AES-128 round keys one at a time. It does not hold the full expanded schedule. It keeps only the four newest 32-bit words. When the cipher asks for the next round, it derives four fresh words from them. The non-linear step of the schedule goes through a single substitution unit that handles one byte per clock. So each new round key takes a few cycles, and far less storage and logic is needed.

A cipher core loads the 128-bit key with a one-cycle strobe, and round 0 (the key itself) is presented on the next cycle. After that, the core pulses a request each time it needs the next key. It watches the valid flag and the round index, which tell it which key is on the output. The round key is presented with word w(4r) in bits 127:96 and w(4r+3) in bits 31:0.

Top module: `rkg_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `keyValid` is 0, `roundIdx` is 0 and `roundKey` is all zeros.
- R2: A `keyLoad` pulse sampled at a clock edge makes `roundKey` equal `keyIn`, `roundIdx` equal 0 and `keyValid` equal 1 after that same edge.
- R3: A request is accepted when `nextReq` is sampled at edge E0 while `keyValid` is 1, `roundIdx` is below 10 and `keyLoad` is 0. After E0, `keyValid` is 0 through edge E4. After edge E5, `keyValid` is 1 and `roundIdx` has gone up by exactly one.
- R4: The new words are computed from the previous four words, called p0..p3. With t = S(RotWord(p3)) XOR (rc << 24), the new words are n0 = p0 XOR t, n1 = p1 XOR n0, n2 = p2 XOR n1 and n3 = p3 XOR n2. RotWord moves the top byte of a word to the bottom. S applies the substitution of R6 to each byte.
- R5: The constant rc is 01 hex for round 1. For each later round it is the previous value times x in GF(2^8) modulo x^8+x^4+x^3+x+1. This gives the sequence 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R6: The byte substitution is done in two steps. The first step takes the multiplicative inverse in GF(2^8) under the same polynomial, with 00 mapped to 00. The second step is the affine map with constant 63 hex, so 00 maps to 63 and 53 maps to ED.
- R7: A `nextReq` that arrives while a round key is being computed (`keyValid` at 0) is ignored. The round index advances by one only, and the result appears at the time R3 gives.
- R8: A `nextReq` at round 10 is ignored. `roundKey`, `roundIdx` and `keyValid` stay unchanged.
- R9: A `keyLoad` during a computation abandons it. The block restarts at round 0 with the new key, and rc goes back to 01.
- R10: When `keyLoad` and `nextReq` are sampled together, the load wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keyLoad | input | 1 | One-cycle strobe that captures `keyIn` |
| keyIn | input | 128 | Cipher key, w0 in bits 127:96 |
| nextReq | input | 1 | Request for the next round key |
| roundKey | output | 128 | Current round key, w(4r) in bits 127:96 |
| keyValid | output | 1 | `roundKey` holds round `roundIdx` |
| roundIdx | output | 4 | Index of the round key on the output, 0 to 10 |

## Verification
The assertions assume that `keyLoad` and `nextReq` are clean levels sampled at the clock. They also assume that `keyIn` is stable during the cycle in which the load is sampled. The bench drives every input on the falling edge, so each strobe covers exactly one rising edge, and it holds `keyIn` steady around that edge. Requests that arrive during a computation, at round 10, or together with a load are sent on purpose, so that the rules for ignoring requests and for load priority are tested. No other input pattern is used.

// File: rtl/rkg_pkg.sv
package rkg_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int SEL_W = $clog2(WORD_BYTES);

  typedef struct packed {
    logic             load;
    logic             subStep;
    logic [SEL_W-1:0] subSel;
    logic             commit;
  } rkgStrobe_t;

  function automatic logic [7:0] gfDouble(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfDouble(sh);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rkg_sbox.sv
module rkg_sbox (
  input  logic [7:0] inByte,
  output logic [7:0] outByte
);
  import rkg_pkg::*;

  localparam logic [7:0] AFF_C = 8'h63;

  logic [7:0] x2, x3, x12, x15, x240, inv;

  // inverse as x^254 = x^240 * x^12 * x^2 (zero stays zero)
  always_comb begin
    x2   = gfMul(inByte, inByte);
    x3   = gfMul(x2, inByte);
    x12  = gfMul(gfMul(x3, x3), gfMul(x3, x3));
    x15  = gfMul(x12, x3);
    x240 = x15;
    for (int k = 0; k < 4; k++) x240 = gfMul(x240, x240);
    inv  = gfMul(gfMul(x240, x12), x2);
  end

  generate
    for (genvar i = 0; i < 8; i++) begin : g_aff
      assign outByte[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8]
                        ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ AFF_C[i];
    end
  endgenerate
endmodule

// File: rtl/rkg_ctrl.sv
module rkg_ctrl #(
  parameter int LAST_ROUND = 10,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    keyLoad,
  input  logic                    nextReq,
  output rkg_pkg::rkgStrobe_t     strobe,
  output logic                    keyValid,
  output logic [IDX_W-1:0]        roundIdx
);
  import rkg_pkg::*;

  localparam int PH_W = SEL_W + 1;
  localparam logic [PH_W-1:0] PH_COMMIT = PH_W'(WORD_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_ROUND);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic            accept;

  assign accept = !keyLoad && !busy && nextReq && keyValid && (roundIdx < IDX_LAST);

  always_comb begin
    strobe.load    = keyLoad;
    strobe.subStep = busy && !keyLoad && (phase < PH_COMMIT);
    strobe.subSel  = phase[SEL_W-1:0];
    strobe.commit  = busy && !keyLoad && (phase == PH_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= '0;
      roundIdx <= '0;
      keyValid <= 1'b0;
    end else if (keyLoad) begin
      busy     <= 1'b0;
      phase    <= '0;
      roundIdx <= '0;
      keyValid <= 1'b1;
    end else if (busy) begin
      if (phase == PH_COMMIT) begin
        busy     <= 1'b0;
        phase    <= '0;
        roundIdx <= roundIdx + 1'b1;
        keyValid <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end else if (accept) begin
      busy     <= 1'b1;
      phase    <= '0;
      keyValid <= 1'b0;
    end
  end

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    roundIdx <= IDX_LAST);

  p_accept_drops_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nextReq && keyValid && !keyLoad && roundIdx < IDX_LAST) |=> !keyValid);

  p_busy_hides_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !keyValid);
endmodule

// File: rtl/rkg_dpath.sv
module rkg_dpath #(
  parameter int KEY_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rkg_pkg::rkgStrobe_t strobe,
  input  logic [KEY_W-1:0]    keyIn,
  output logic [KEY_W-1:0]    roundKey
);
  import rkg_pkg::*;

  localparam int NWORDS = KEY_W / WORD_W;

  logic [WORD_W-1:0] wReg [NWORDS];
  logic [WORD_W-1:0] nextW [NWORDS];
  logic [WORD_W-1:0] subW;
  logic [WORD_W-1:0] rotW;
  logic [WORD_W-1:0] tmix;
  logic [7:0]        rcon;
  logic [7:0]        sbIn, sbOut;

  assign rotW = {wReg[NWORDS-1][WORD_W-9:0], wReg[NWORDS-1][WORD_W-1:WORD_W-8]};
  assign sbIn = rotW[WORD_W-1 - 8*strobe.subSel -: 8];

  rkg_sbox sbox_i (.inByte(sbIn), .outByte(sbOut));

  assign tmix = subW ^ {rcon, {(WORD_W-8){1'b0}}};

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_words
      if (i == 0) begin : g_first
        assign nextW[i] = wReg[i] ^ tmix;
      end else begin : g_rest
        assign nextW[i] = wReg[i] ^ nextW[i-1];
      end
      assign roundKey[KEY_W-1 - WORD_W*i -: WORD_W] = wReg[i];

      always_ff @(posedge clk) begin
        if (!rst_n)             wReg[i] <= '0;
        else if (strobe.load)   wReg[i] <= keyIn[KEY_W-1 - WORD_W*i -: WORD_W];
        else if (strobe.commit) wReg[i] <= nextW[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subW <= '0;
      rcon <= 8'h01;
    end else if (strobe.load) begin
      subW <= '0;
      rcon <= 8'h01;
    end else begin
      if (strobe.subStep) subW[WORD_W-1 - 8*strobe.subSel -: 8] <= sbOut;
      if (strobe.commit)  rcon <= gfDouble(rcon);
    end
  end

  p_rcon_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rcon) == 1 || rcon == 8'h1B || rcon == 8'h36 || rcon == 8'h6C);

  p_key_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && !strobe.commit) |=> $stable(roundKey));
endmodule

// File: rtl/rkg_top.sv
module rkg_top #(
  parameter int KEY_W = 128,
  parameter int LAST_ROUND = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keyLoad,
  input  logic [KEY_W-1:0] keyIn,
  input  logic             nextReq,
  output logic [KEY_W-1:0] roundKey,
  output logic             keyValid,
  output logic [IDX_W-1:0] roundIdx
);
  import rkg_pkg::*;

  rkgStrobe_t strobe;

  rkg_ctrl #(.LAST_ROUND(LAST_ROUND), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .keyLoad(keyLoad), .nextReq(nextReq),
    .strobe(strobe), .keyValid(keyValid), .roundIdx(roundIdx));

  rkg_dpath #(.KEY_W(KEY_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .keyIn(keyIn), .roundKey(roundKey));

  p_load_presents_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    keyLoad |=> (keyValid && roundIdx == '0 && roundKey == $past(keyIn)));

  p_last_round_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (keyValid && roundIdx == IDX_W'(LAST_ROUND) && !keyLoad) |=>
      (keyValid && roundIdx == IDX_W'(LAST_ROUND) && $stable(roundKey)));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(keyValid) && !$past(keyLoad)) |-> roundIdx == $past(roundIdx) + 1'b1);
endmodule

// File: tb/rkg_top_tb_top.sv
module rkg_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         nextReq = 1'b0;
  logic [127:0] roundKey;
  logic         keyValid;
  logic [3:0]   roundIdx;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'hACE1_2024;

  always #5 clk = ~clk;

  rkg_top dut_i (.clk(clk), .rst_n(rst_n), .keyLoad(keyLoad), .keyIn(keyIn),
                 .nextReq(nextReq), .roundKey(roundKey), .keyValid(keyValid),
                 .roundIdx(roundIdx));

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference arithmetic, written independently of the design
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] b);
    logic [7:0] v = 8'h00;
    logic [7:0] s;
    for (int c = 1; c < 256; c++) if (b != 0 && refMul(b, 8'(c)) == 8'h01) v = 8'(c);
    s = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    return s;
  endfunction

  function automatic logic [127:0] refNext(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] w [4];
    logic [31:0] r, t;
    for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
    r = {w[3][23:0], w[3][31:24]};
    t = {refSbox(r[31:24]), refSbox(r[23:16]), refSbox(r[15:8]), refSbox(r[7:0])} ^ {rc, 24'h0};
    w[0] = w[0] ^ t;
    for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
    return {w[0], w[1], w[2], w[3]};
  endfunction

  function automatic logic [7:0] refRc(input int round);
    logic [7:0] rc = 8'h01;
    for (int i = 1; i < round; i++) rc = refMul(rc, 8'h02);
    return rc;
  endfunction

  task automatic loadKey(input logic [127:0] k);
    @(negedge clk);
    keyIn = k; keyLoad = 1'b1;
    @(negedge clk);
    keyLoad = 1'b0;
    check(keyValid === 1'b1 && roundIdx === 4'd0 && roundKey === k, "R2 load", roundKey, k);
  endtask

  // request for one round; extra holds nextReq high during the busy window (R7)
  task automatic stepRound(input logic [127:0] expKey, input int expIdx, input bit extra);
    @(negedge clk);
    nextReq = 1'b1;
    @(negedge clk);
    if (!extra) nextReq = 1'b0;
    check(keyValid === 1'b0, "R3 valid drops", 128'(keyValid), 128'd0);
    repeat (3) @(negedge clk);
    nextReq = 1'b0;
    @(negedge clk);
    check(keyValid === 1'b0, "R3 still busy after E4", 128'(keyValid), 128'd0);
    @(negedge clk);
    check(keyValid === 1'b1 && roundIdx === 4'(expIdx), "R3 R7 valid and index after E5",
          {keyValid, 123'd0, roundIdx}, {1'b1, 123'd0, 4'(expIdx)});
    check(roundKey === expKey, "R4 R5 R6 round key", roundKey, expKey);
  endtask

  task automatic fullSchedule(input logic [127:0] k, input bit extra);
    logic [127:0] cur = k;
    loadKey(k);
    for (int r = 1; r <= 10; r++) begin
      cur = refNext(cur, refRc(r));
      stepRound(cur, r, extra);
    end
    @(negedge clk);
    nextReq = 1'b1;
    repeat (6) @(negedge clk);
    nextReq = 1'b0;
    check(keyValid === 1'b1 && roundIdx === 4'd10 && roundKey === cur,
          "R8 request at last round ignored", roundKey, cur);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(keyValid === 1'b0 && roundIdx === 4'd0 && roundKey === '0, "R1 in reset", roundKey, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(keyValid === 1'b0 && roundIdx === 4'd0 && roundKey === '0, "R1 after reset", roundKey, '0);

    // R6 spot values of the reference substitution
    check(refSbox(8'h00) == 8'h63 && refSbox(8'h53) == 8'hED, "R6 reference sbox",
          128'({refSbox(8'h00), refSbox(8'h53)}), 128'h63ED);
    // R5 rc sequence of the model
    check(refRc(9) == 8'h1B && refRc(10) == 8'h36, "R5 constants",
          128'({refRc(9), refRc(10)}), 128'h1B36);

    // well-known example key, final round key
    fullSchedule(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
    check(roundKey === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 example round 10",
          roundKey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    fullSchedule(128'h0, 1'b1);
    fullSchedule({128{1'b1}}, 1'b0);

    // R9: load in the middle of a computation restarts at round 0
    loadKey(128'h000102030405060708090a0b0c0d0e0f);
    @(negedge clk); nextReq = 1'b1;
    @(negedge clk); nextReq = 1'b0;
    @(negedge clk);
    loadKey(128'h2b7e151628aed2a6abf7158809cf4f3c);
    stepRound(128'ha0fafe1788542cb123a339392a6c7605, 1, 1'b0);
    check(roundKey === 128'ha0fafe1788542cb123a339392a6c7605, "R9 restart uses rc 01",
          roundKey, 128'ha0fafe1788542cb123a339392a6c7605);

    // R10: load and request together
    @(negedge clk);
    keyIn = 128'h00112233445566778899aabbccddeeff; keyLoad = 1'b1; nextReq = 1'b1;
    @(negedge clk);
    keyLoad = 1'b0; nextReq = 1'b0;
    @(negedge clk);
    check(keyValid === 1'b1 && roundIdx === 4'd0 && roundKey === 128'h00112233445566778899aabbccddeeff,
          "R10 load wins over request", roundKey, 128'h00112233445566778899aabbccddeeff);

    // sweep over pseudo-random keys
    for (int n = 0; n < 24; n++) begin
      logic [127:0] k;
      for (int j = 0; j < 4; j++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        k[32*j +: 32] = lfsr;
      end
      fullSchedule(k, n[0]);
    end

    finishRun();
  end
endmodule